// File: doc/BRIEF.md
# Conditional Relative Branch Executor

This block carries out the execution steps of a short conditional branch inside a small processor model that keeps a byte-wide prefetch queue in front of execution. Once decode hands it a branch through a start pulse, it takes one signed displacement byte from the queue and samples a condition-met input. It then either ends after a fixed short sequence, or it pauses prefetching and builds a new program counter from the counter corrected for queue lookahead plus the sign-extended displacement. It then loads that value and empties the queue.

The fetch counter always points at the next byte to be fetched, which lies ahead of the next byte to be executed by however many bytes sit in the queue. The block therefore subtracts the queue occupancy before the add. Both paths have a fixed length, 4 clocks when not taken and 8 when taken, and each ends with a dead cycle in which the next instruction is decoded.

Top module: `relbr_exec`

## Requirements
- R1: While reset is held, and after it, `q_pop`, `pf_suspend`, `q_flush`, `pc_load` and `br_done` are all 0 and `pc_next` is 0, until a branch is started.
- R2: A `br_start` seen while idle moves the block to its fetch step. It then waits there without advancing while `q_valid` is 0, with `q_pop` kept at 0. In the first cycle with `q_valid` = 1, `q_pop` is 1 and `q_byte` is taken as the displacement. That cycle is cycle 1 of the branch.
- R3: When not taken, `br_done` is 1 only in cycle 4, and `pf_suspend`, `pc_load` and `q_flush` stay 0 during the whole branch.
- R4: When taken, `pf_suspend` is 1 in cycles 4 to 7, `pc_load` and `q_flush` are both 1 only in cycle 7, and `br_done` is 1 only in cycle 8.
- R5: In the `pc_load` cycle, `pc_next` equals `fetch_pc` minus `q_count` plus the sign-extended displacement, with `fetch_pc` and `q_count` taken in cycle 5, when prefetch is already suspended.
- R6: The displacement is two's complement: bit 7 = 1 gives a negative offset, so the reach is from 128 bytes back (0x80) to 127 bytes forward (0x7F) of the corrected counter.
- R7: `cond_met` is sampled only in cycle 2 (1 = taken). Its value in any other cycle has no effect on the outcome.
- R8: The correction and the add are 16 bits wide and wrap modulo 2^16 in both directions.
- R9: `br_start` has no effect while a branch is in progress. `br_done` lasts one cycle, and the block is idle in the cycle after it, ready for a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| br_start | input | 1 | Decode hands over a conditional branch |
| q_byte | input | 8 | Byte at the head of the prefetch queue |
| q_valid | input | 1 | Queue head holds a valid byte |
| q_count | input | 3 | Valid bytes left in the queue |
| cond_met | input | 1 | Branch condition is true |
| fetch_pc | input | 16 | Address of the next byte to prefetch |
| q_pop | output | 1 | Head byte consumed this cycle |
| pf_suspend | output | 1 | Hold prefetching |
| q_flush | output | 1 | Empty the prefetch queue |
| pc_load | output | 1 | Load `pc_next` into the program counter |
| pc_next | output | 16 | Branch target |
| br_done | output | 1 | Last (dead) cycle of the branch |

## Verification
Each branch is counted from the cycle in which `q_pop` rises. `cond_met` matters one cycle later, `pf_suspend` covers cycles 4 to 7 on the taken path, the target and its strobes appear in cycle 7, and `br_done` comes in cycle 4 or 8. The bench drives inputs at the falling edge and samples one nanosecond later, so every value it reads comes from the state settled after the preceding rising edge. It records the cycle number of each strobe and compares those numbers with the fixed schedule, rather than waiting on events. Stall and held-start runs check that waiting in the fetch step and repeated starts do not shift that schedule.

// File: rtl/relbr_pkg.sv
package relbr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FETCH,
    ST_TEST,
    ST_RNI,
    ST_JMP,
    ST_SUSP,
    ST_CORR,
    ST_ADD,
    ST_WRPC,
    ST_DEAD
  } brst_t;
endpackage

// File: rtl/relbr_rstsync.sv
module relbr_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/relbr_ctl.sv
module relbr_ctl
  import relbr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  q_valid,
  input  logic  cond_met,
  output brst_t state,
  output logic  ld_disp,
  output logic  ld_corr,
  output logic  ld_sum
);
  brst_t state_q, state_d;

  // next-state process
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start)   state_d = ST_FETCH;
      ST_FETCH: if (q_valid) state_d = ST_TEST;
      ST_TEST:  state_d = cond_met ? ST_JMP : ST_RNI;
      ST_RNI:   state_d = ST_DEAD;
      ST_JMP:   state_d = ST_SUSP;
      ST_SUSP:  state_d = ST_CORR;
      ST_CORR:  state_d = ST_ADD;
      ST_ADD:   state_d = ST_WRPC;
      ST_WRPC:  state_d = ST_DEAD;
      ST_DEAD:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state   = state_q;
  assign ld_disp = (state_q == ST_FETCH) && q_valid;
  assign ld_corr = (state_q == ST_CORR);
  assign ld_sum  = (state_q == ST_ADD);
endmodule

// File: rtl/relbr_dp.sv
module relbr_dp #(
  parameter int PC_W   = 16,
  parameter int DISP_W = 8,
  parameter int QCNT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_disp,
  input  logic              ld_corr,
  input  logic              ld_sum,
  input  logic [DISP_W-1:0] q_byte,
  input  logic [PC_W-1:0]   fetch_pc,
  input  logic [QCNT_W-1:0] q_count,
  output logic [PC_W-1:0]   sum
);
  localparam int EXT_W = PC_W - DISP_W;

  logic [DISP_W-1:0] opb_q, opb_d;
  logic [PC_W-1:0]   opa_q, opa_d;
  logic [PC_W-1:0]   sum_q, sum_d;
  logic [PC_W-1:0]   disp_ext;

  assign disp_ext = {{EXT_W{opb_q[DISP_W-1]}}, opb_q};

  // next values with clock enables written out
  always_comb begin
    opb_d = opb_q;
    opa_d = opa_q;
    sum_d = sum_q;
    if (ld_disp) opb_d = q_byte;
    if (ld_corr) opa_d = fetch_pc - PC_W'(q_count);
    if (ld_sum)  sum_d = opa_q + disp_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opb_q <= '0;
      opa_q <= '0;
      sum_q <= '0;
    end else begin
      opb_q <= opb_d;
      opa_q <= opa_d;
      sum_q <= sum_d;
    end
  end

  assign sum = sum_q;
endmodule

// File: rtl/relbr_strobe.sv
module relbr_strobe
  import relbr_pkg::*;
(
  input  brst_t state,
  input  logic  q_valid,
  output logic  q_pop,
  output logic  pf_suspend,
  output logic  q_flush,
  output logic  pc_load,
  output logic  br_done
);
  always_comb begin
    q_pop      = 1'b0;
    pf_suspend = 1'b0;
    q_flush    = 1'b0;
    pc_load    = 1'b0;
    br_done    = 1'b0;
    unique case (state)
      ST_FETCH: q_pop = q_valid;
      ST_SUSP, ST_CORR, ST_ADD: pf_suspend = 1'b1;
      ST_WRPC: begin
        pf_suspend = 1'b1;
        q_flush    = 1'b1;
        pc_load    = 1'b1;
      end
      ST_DEAD: br_done = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/relbr_exec.sv
module relbr_exec
  import relbr_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DISP_W = 8,
  parameter int QDEPTH = 6,
  parameter int QCNT_W = $clog2(QDEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_start,
  input  logic [DISP_W-1:0] q_byte,
  input  logic              q_valid,
  input  logic [QCNT_W-1:0] q_count,
  input  logic              cond_met,
  input  logic [PC_W-1:0]   fetch_pc,
  output logic              q_pop,
  output logic              pf_suspend,
  output logic              q_flush,
  output logic              pc_load,
  output logic [PC_W-1:0]   pc_next,
  output logic              br_done
);
  logic  rst_i_n;
  brst_t state;
  logic  ld_disp, ld_corr, ld_sum;

  relbr_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  relbr_ctl u_ctl (
    .clk(clk), .rst_n(rst_i_n), .start(br_start), .q_valid(q_valid),
    .cond_met(cond_met), .state(state), .ld_disp(ld_disp),
    .ld_corr(ld_corr), .ld_sum(ld_sum)
  );

  relbr_dp #(.PC_W(PC_W), .DISP_W(DISP_W), .QCNT_W(QCNT_W)) u_dp (
    .clk(clk), .rst_n(rst_i_n), .ld_disp(ld_disp), .ld_corr(ld_corr),
    .ld_sum(ld_sum), .q_byte(q_byte), .fetch_pc(fetch_pc),
    .q_count(q_count), .sum(pc_next)
  );

  relbr_strobe u_str (
    .state(state), .q_valid(q_valid), .q_pop(q_pop),
    .pf_suspend(pf_suspend), .q_flush(q_flush), .pc_load(pc_load),
    .br_done(br_done)
  );
endmodule

// File: rtl/relbr_exec_chk.sv
module relbr_exec_chk (
  input logic clk,
  input logic rst_n,
  input logic q_valid,
  input logic q_pop,
  input logic pf_suspend,
  input logic q_flush,
  input logic pc_load,
  input logic br_done
);
  a_r2_pop_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop |-> q_valid);
  a_r4_flush_under_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    q_flush |-> pf_suspend);
  a_r4_load_with_flush: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> q_flush);
  a_r4_done_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> (br_done && !pf_suspend));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    br_done |=> !br_done);
  a_r3_quiet_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    br_done |-> (!pf_suspend && !pc_load && !q_pop));
endmodule

bind relbr_exec relbr_exec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_pop(q_pop),
  .pf_suspend(pf_suspend), .q_flush(q_flush), .pc_load(pc_load),
  .br_done(br_done)
);

// File: tb/relbr_exec_test.sv
module relbr_exec_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        br_start;
  logic [7:0]  q_byte;
  logic        q_valid;
  logic [2:0]  q_count;
  logic        cond_met;
  logic [15:0] fetch_pc;
  logic        q_pop, pf_suspend, q_flush, pc_load, br_done;
  logic [15:0] pc_next;
  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  relbr_exec uut (
    .clk(clk), .rst_n(rst_n), .br_start(br_start), .q_byte(q_byte),
    .q_valid(q_valid), .q_count(q_count), .cond_met(cond_met),
    .fetch_pc(fetch_pc), .q_pop(q_pop), .pf_suspend(pf_suspend),
    .q_flush(q_flush), .pc_load(pc_load), .pc_next(pc_next),
    .br_done(br_done)
  );

  // vectors: displacement, condition, fetch counter, queue count, expected target
  localparam int NV = 8;
  localparam logic [7:0]  V_DISP [NV] = '{8'h10, 8'hF0, 8'h7F, 8'h80, 8'h05, 8'hFF, 8'h7F, 8'h80};
  localparam logic        V_COND [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [15:0] V_FPC  [NV] = '{16'h1000, 16'h2000, 16'h0100, 16'h0100,
                                          16'h3000, 16'h0001, 16'hFFF0, 16'h4000};
  localparam logic [2:0]  V_QC   [NV] = '{3'd2, 3'd4, 3'd0, 3'd5, 3'd3, 3'd3, 3'd1, 3'd6};
  localparam logic [15:0] V_EXP  [NV] = '{16'h100E, 16'h1FEC, 16'h017F, 16'h007B,
                                          16'h0000, 16'hFFFD, 16'h006E, 16'h0000};

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_outputs(input string req);
    check(!q_pop && !pf_suspend && !q_flush && !pc_load && !br_done, req,
          "strobes idle", {q_pop, pf_suspend, q_flush, pc_load, br_done}, 0);
  endtask

  task automatic run_branch(input logic [7:0] d, input logic c, input logic [15:0] fpc,
                            input logic [2:0] qc, input int stall, input bit hold,
                            input logic [15:0] exp_pc);
    int susp_n = 0, susp_first = 0, ld_cyc = 0, fl_cyc = 0, done_cyc = 0, done_n = 0;
    int n = 1;
    bit pop_early = 0;
    logic [15:0] got = '0;
    @(negedge clk);
    br_start = 1'b1; fetch_pc = fpc; q_count = qc; cond_met = ~c; q_valid = 1'b0;
    @(negedge clk);
    br_start = hold;
    for (int s = 0; s < stall; s++) begin
      #1 if (q_pop || br_done) pop_early = 1;
      @(negedge clk);
    end
    q_valid = 1'b1; q_byte = d;
    #1;
    check(!pop_early, "R2", "no pop while queue empty", pop_early, 0);
    check(q_pop == 1'b1, "R2", "pop on valid byte", q_pop, 1);
    while (n < 12) begin
      @(negedge clk);
      n++;
      q_valid = 1'b0; q_byte = ~d;
      cond_met = (n == 2) ? c : ~c;  // R7: other cycles carry the opposite value
      if (n >= 6) br_start = 1'b0;
      #1;
      if (pf_suspend) begin susp_n++; if (susp_first == 0) susp_first = n; end
      if (pc_load) begin ld_cyc = n; got = pc_next; end
      if (q_flush) fl_cyc = n;
      if (br_done) begin done_n++; if (done_cyc == 0) done_cyc = n; end
      if (br_done) break;
    end
    if (c) begin
      check(done_cyc == 8, "R4", "taken done cycle (R7 cond sample)", done_cyc, 8);
      check(susp_n == 4 && susp_first == 4, "R4", "suspend window", susp_first, 4);
      check(ld_cyc == 7 && fl_cyc == 7, "R4", "load/flush cycle", ld_cyc, 7);
      check(got == exp_pc, "R5", "target (R6 sign, R8 wrap)", got, exp_pc);
    end else begin
      check(done_cyc == 4, "R3", "not-taken done cycle (R7 cond sample)", done_cyc, 4);
      check(susp_n == 0 && ld_cyc == 0 && fl_cyc == 0, "R3", "no redirect", susp_n, 0);
    end
    @(negedge clk);
    #1;
    check(!br_done && !q_pop, "R9", "done single cycle then idle", br_done, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; br_start = 1'b0; q_byte = '0; q_valid = 1'b0;
    q_count = '0; cond_met = 1'b0; fetch_pc = '0;
    #1;
    idle_outputs("R1");
    check(pc_next == 16'h0, "R1", "target reset value", pc_next, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 idle_outputs("R1");

    for (int i = 0; i < NV; i++)
      run_branch(V_DISP[i], V_COND[i], V_FPC[i], V_QC[i], 0, 1'b0, V_EXP[i]);

    // R2: stalled fetch step keeps the schedule
    run_branch(8'h20, 1'b1, 16'h5000, 3'd2, 3, 1'b0, 16'h501E);
    run_branch(8'h20, 1'b0, 16'h5000, 3'd2, 2, 1'b0, 16'h0000);
    // R9: start held high while busy
    run_branch(8'hFE, 1'b1, 16'h6000, 3'd0, 0, 1'b1, 16'h5FFE);

    // R1: reset in the middle of a taken branch
    @(negedge clk);
    br_start = 1'b1; fetch_pc = 16'h7000; q_count = 3'd1; cond_met = 1'b1;
    @(negedge clk);
    br_start = 1'b0; q_valid = 1'b1; q_byte = 8'h08;
    repeat (4) @(negedge clk);
    q_valid = 1'b0;
    rst_n = 1'b0;
    #1 idle_outputs("R1");
    check(pc_next == 16'h0, "R1", "target cleared by reset", pc_next, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 idle_outputs("R1");
    run_branch(8'h08, 1'b1, 16'h7000, 3'd1, 0, 1'b0, 16'h7007);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule